// File: doc/BRIEF.md
# Two-Tier DMA Channel Arbiter

This block decides which of several DMA channels owns the shared transfer engine. Each channel presents a request line, an enable bit and a tier bit. The tier bit places the channel in either the urgent tier or the normal tier. A request from the urgent tier always outranks one from the normal tier. Inside a tier the channel with the smaller index wins. The arbiter drives a one-hot grant vector, the granted channel's index and a valid flag.

Once a channel holds the grant, it keeps it for a burst of 2^R transfers. R is a per-channel exponent field. The engine reports each finished transfer with a one-cycle pulse. Arbitration runs again at the burst boundary, or earlier if the owner signals the end of its DMA cycle or loses its enable. A request that arrives in mid-burst waits until that boundary; there is no preemption.

When a boundary is reached, the next owner is chosen and registered on the same clock edge, so bursts can follow each other with no gap. When no channel is eligible, the block idles without a grant. It issues a grant on the first edge after an eligible request appears.

Top module: `dma_tier_arbiter`

## Requirements
- R1: After reset, grant_o is all zero, grant_valid_o is 0 and grant_idx_o is 0.
- R2: grant_o has at most one bit set. grant_valid_o is 1 exactly when one bit is set, and grant_idx_o then gives that bit's position.
- R3: Among eligible channels of the same tier, the channel with the lowest index is granted.
- R4: If any eligible channel has its urgent bit (urgent_i[c] = 1) set, an urgent channel is granted ahead of every normal-tier channel.
- R5: Only a channel with both req_i[c] = 1 and en_i[c] = 1 can be granted. A requesting channel whose enable is 0 never receives the grant.
- R6: While a burst is in progress, the grant does not change, even when a higher-ranked request appears.
- R7: A burst ends on the 2^R-th xfer_done_i pulse, where R is burst_exp_i[c*EXP_W +: EXP_W] of the granted channel, sampled when the grant is given. Values above MAX_EXP (default 10) count as MAX_EXP, so a burst has 1 to 1024 transfers.
- R8: The burst ends early when cyc_end_i of the granted channel is 1, or when the granted channel's en_i drops to 0.
- R9: When no channel is eligible, no grant is given. A grant appears on the first clock edge at which an eligible request is present.
- R10: At a burst boundary the next winner is chosen from the inputs of that cycle and takes the grant on the same edge. If no channel is eligible, the arbiter returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_CH | Per-channel transfer request |
| en_i | input | NUM_CH | Per-channel enable |
| urgent_i | input | NUM_CH | Per-channel tier select, 1 = urgent tier |
| burst_exp_i | input | NUM_CH*EXP_W | Per-channel burst exponent R, channel c at bits c*EXP_W +: EXP_W |
| xfer_done_i | input | 1 | One-cycle pulse per finished transfer of the granted channel |
| cyc_end_i | input | NUM_CH | Per-channel end-of-DMA-cycle indication |
| grant_o | output | NUM_CH | One-hot grant |
| grant_idx_o | output | IDX_W | Index of the granted channel |
| grant_valid_o | output | 1 | A channel currently holds the grant |

## Verification
The bound checker checks the following on every cycle:
- The grant stays one-hot, and the index and valid flag agree with it.
- Every new grant goes to a channel that was eligible in the previous cycle.
- The urgent tier is honoured whenever it had a candidate.
- The grant stays put unless a boundary occurred.
- A channel never holds the grant for more transfers than its burst allows.
- Without eligible requests, an idle arbiter stays idle.

The exact order inside each tier, the clamping of large exponents to 1024 transfers, and the early release on end-of-cycle or lost enable need planned request patterns. The same is true of back-to-back handover at a boundary. The directed scenarios in the bench show these.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
   // Implementation choice for the lowest-index pick logic.
   typedef enum logic {
      PICK_SCAN    = 1'b0,
      PICK_ISOLATE = 1'b1
   } pick_style_e;

   // Ownership state of the engine.
   typedef enum logic {
      ARB_IDLE = 1'b0,
      ARB_HOLD = 1'b1
   } arb_state_e;
endpackage

// File: rtl/dma_arb_pick.sv
// Lowest-index picker: returns a one-hot of the lowest set bit and its index.
module dma_arb_pick
   import dma_arb_pkg::*;
#(
   parameter int          WIDTH = 8,
   parameter pick_style_e STYLE = PICK_ISOLATE,
   localparam int         IW    = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [WIDTH-1:0] vec_i,
   output logic             any_o,
   output logic [WIDTH-1:0] onehot_o,
   output logic [IW-1:0]    idx_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("dma_arb_pick: WIDTH must be at least 1");
   end

   assign any_o = |vec_i;

   if (STYLE == PICK_SCAN) begin : g_scan
      // Walk from the top so that the lowest set bit is written last.
      always_comb begin
         onehot_o = '0;
         idx_o    = '0;
         for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
               onehot_o    = '0;
               onehot_o[i] = 1'b1;
               idx_o       = IW'(i);
            end
         end
      end
   end else begin : g_isolate
      // Two's-complement trick isolates the lowest set bit, then OR-encode.
      assign onehot_o = vec_i & (~vec_i + WIDTH'(1));
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < WIDTH; i++) begin
            if (onehot_o[i]) idx_o = idx_o | IW'(i);
         end
      end
   end

endmodule

// File: rtl/dma_arb_tier_sel.sv
// Two-tier winner selection: the urgent tier first, lowest index inside a tier.
module dma_arb_tier_sel
   import dma_arb_pkg::*;
#(
   parameter int          NUM_CH = 8,
   parameter pick_style_e STYLE  = PICK_ISOLATE,
   localparam int         IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [NUM_CH-1:0] elig_i,
   input  logic [NUM_CH-1:0] urgent_i,
   output logic              any_o,
   output logic [NUM_CH-1:0] onehot_o,
   output logic [IDX_W-1:0]  idx_o
);

   logic [NUM_CH-1:0] hi_vec, lo_vec;
   logic              hi_any, lo_any;
   logic [NUM_CH-1:0] hi_oh, lo_oh;
   logic [IDX_W-1:0]  hi_idx, lo_idx;

   assign hi_vec = elig_i & urgent_i;
   assign lo_vec = elig_i & ~urgent_i;

   dma_arb_pick #(.WIDTH(NUM_CH), .STYLE(STYLE)) u_pick_hi (
      .vec_i    (hi_vec),
      .any_o    (hi_any),
      .onehot_o (hi_oh),
      .idx_o    (hi_idx)
   );

   dma_arb_pick #(.WIDTH(NUM_CH), .STYLE(STYLE)) u_pick_lo (
      .vec_i    (lo_vec),
      .any_o    (lo_any),
      .onehot_o (lo_oh),
      .idx_o    (lo_idx)
   );

   assign any_o    = hi_any | lo_any;
   assign onehot_o = hi_any ? hi_oh  : lo_oh;
   assign idx_o    = hi_any ? hi_idx : lo_idx;

endmodule

// File: rtl/dma_arb_burst_ctr.sv
// Counts the transfers left in a burst of 2^R, with R clamped to MAX_EXP.
module dma_arb_burst_ctr #(
   parameter int  EXP_W   = 4,
   parameter int  MAX_EXP = 10,
   localparam int CNT_W   = (MAX_EXP < 1) ? 1 : MAX_EXP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [EXP_W-1:0] exp_i,
   input  logic             step_i,
   output logic             last_o
);

   if (((1 << EXP_W) - 1) < MAX_EXP) begin : g_bad_exp_w
      $error("dma_arb_burst_ctr: EXP_W too narrow for MAX_EXP");
   end
   if (MAX_EXP > 20) begin : g_bad_max
      $error("dma_arb_burst_ctr: MAX_EXP above 20 not supported");
   end

   logic [EXP_W-1:0] exp_eff;
   logic [CNT_W-1:0] remain_q;   // transfers left minus one

   assign exp_eff = (exp_i > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exp_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (load_i) begin
         remain_q <= CNT_W'((32'd1 << exp_eff) - 32'd1);
      end else if (step_i && (remain_q != '0)) begin
         remain_q <= remain_q - CNT_W'(1);
      end
   end

   assign last_o = (remain_q == '0);

endmodule

// File: rtl/dma_tier_arbiter.sv
module dma_tier_arbiter
   import dma_arb_pkg::*;
#(
   parameter int          NUM_CH     = 8,
   parameter int          EXP_W      = 4,
   parameter int          MAX_EXP    = 10,
   parameter pick_style_e PICK_STYLE = PICK_ISOLATE,
   localparam int         IDX_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CH-1:0]       req_i,
   input  logic [NUM_CH-1:0]       en_i,
   input  logic [NUM_CH-1:0]       urgent_i,
   input  logic [NUM_CH*EXP_W-1:0] burst_exp_i,
   input  logic                    xfer_done_i,
   input  logic [NUM_CH-1:0]       cyc_end_i,
   output logic [NUM_CH-1:0]       grant_o,
   output logic [IDX_W-1:0]        grant_idx_o,
   output logic                    grant_valid_o
);

   if (NUM_CH < 2) begin : g_bad_nch
      $error("dma_tier_arbiter: NUM_CH must be at least 2");
   end

   arb_state_e        state_q;
   logic [NUM_CH-1:0] grant_q;
   logic [IDX_W-1:0]  idx_q;

   logic [NUM_CH-1:0] elig;
   logic              win_any;
   logic [NUM_CH-1:0] win_oh;
   logic [IDX_W-1:0]  win_idx;
   logic [EXP_W-1:0]  win_exp;
   logic              burst_last;
   logic              owner_end;
   logic              rearb;

   assign elig = req_i & en_i;

   dma_arb_tier_sel #(.NUM_CH(NUM_CH), .STYLE(PICK_STYLE)) u_sel (
      .elig_i   (elig),
      .urgent_i (urgent_i),
      .any_o    (win_any),
      .onehot_o (win_oh),
      .idx_o    (win_idx)
   );

   assign win_exp = burst_exp_i[win_idx*EXP_W +: EXP_W];

   // Boundary of the current ownership: burst used up, cycle over, or enable lost.
   assign owner_end = (state_q == ARB_HOLD) &&
                      (!en_i[idx_q] || cyc_end_i[idx_q] || (xfer_done_i && burst_last));
   assign rearb     = (state_q == ARB_IDLE) || owner_end;

   dma_arb_burst_ctr #(.EXP_W(EXP_W), .MAX_EXP(MAX_EXP)) u_burst (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (rearb && win_any),
      .exp_i  (win_exp),
      .step_i ((state_q == ARB_HOLD) && xfer_done_i && !rearb),
      .last_o (burst_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ARB_IDLE;
         grant_q <= '0;
         idx_q   <= '0;
      end else if (rearb) begin
         if (win_any) begin
            state_q <= ARB_HOLD;
            grant_q <= win_oh;
            idx_q   <= win_idx;
         end else begin
            state_q <= ARB_IDLE;
            grant_q <= '0;
            idx_q   <= '0;
         end
      end
   end

   assign grant_o       = grant_q;
   assign grant_idx_o   = idx_q;
   assign grant_valid_o = (state_q == ARB_HOLD);

endmodule

// File: rtl/dma_tier_arbiter_chk.sv
module dma_tier_arbiter_chk #(
   parameter int  NUM_CH  = 8,
   parameter int  EXP_W   = 4,
   parameter int  MAX_EXP = 10,
   localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int XC_W    = MAX_EXP + 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NUM_CH-1:0]       req_i,
   input logic [NUM_CH-1:0]       en_i,
   input logic [NUM_CH-1:0]       urgent_i,
   input logic [NUM_CH*EXP_W-1:0] burst_exp_i,
   input logic                    xfer_done_i,
   input logic [NUM_CH-1:0]       cyc_end_i,
   input logic [NUM_CH-1:0]       grant_o,
   input logic [IDX_W-1:0]        grant_idx_o,
   input logic                    grant_valid_o
);

   // Independent transfer count of the current owner; the exponent is held
   // steady by the system while a channel owns the engine.
   logic [EXP_W-1:0] own_exp, own_eff;
   logic [XC_W-1:0]  limit, xcnt;
   logic             bound;

   assign own_exp = burst_exp_i[grant_idx_o*EXP_W +: EXP_W];
   assign own_eff = (own_exp > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : own_exp;
   assign limit   = XC_W'(1) << own_eff;
   assign bound   = grant_valid_o &&
                    (!en_i[grant_idx_o] || cyc_end_i[grant_idx_o] ||
                     (xfer_done_i && (xcnt == limit - XC_W'(1))));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      xcnt <= '0;
      else if (!grant_valid_o || bound) xcnt <= '0;
      else if (xfer_done_i)            xcnt <= xcnt + XC_W'(1);
   end

   p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o) && (grant_valid_o == (grant_o != '0)));

   p_idx_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid_o |-> grant_o[grant_idx_o]);

   p_eligible_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid_o && (!$past(grant_valid_o) || $past(bound)))
      |-> ((grant_o & $past(req_i & en_i)) != '0));

   p_urgent_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid_o && (!$past(grant_valid_o) || $past(bound)) &&
       $past((req_i & en_i & urgent_i) != '0))
      |-> ((grant_o & $past(urgent_i)) != '0));

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(grant_valid_o) && !$past(bound)) |-> (grant_valid_o && $stable(grant_o)));

   p_burst_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid_o |-> (xcnt < limit));

   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(grant_valid_o) && ($past(req_i & en_i) == '0)) |-> !grant_valid_o);

endmodule

bind dma_tier_arbiter dma_tier_arbiter_chk #(
   .NUM_CH(NUM_CH), .EXP_W(EXP_W), .MAX_EXP(MAX_EXP)
) u_chk (.*);

// File: tb/dma_tier_arbiter_test.sv
module dma_tier_arbiter_test;
   localparam int N  = 8;
   localparam int EW = 4;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0, en = '0, urg = '0, cend = '0;
   logic [N*EW-1:0] bexp = '0;
   logic          done = 1'b0;
   logic [N-1:0]  grant;
   logic [IW-1:0] gidx;
   logic          gvalid;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   dma_tier_arbiter uut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .en_i(en), .urgent_i(urg),
      .burst_exp_i(bexp), .xfer_done_i(done), .cyc_end_i(cend),
      .grant_o(grant), .grant_idx_o(gidx), .grant_valid_o(gvalid)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic set_exp(input int ch, input int val);
      bexp[ch*EW +: EW] = EW'(val);
   endtask

   task automatic expect_grant(input bit v, input int ch, input string tag);
      logic [N-1:0] eoh;
      eoh = v ? (N'(1) << ch) : '0;
      checks++;
      if (gvalid !== v || grant !== eoh || (v && gidx !== IW'(ch))) begin
         fails++;
         $display("FAIL %s: valid=%0b grant=%b idx=%0d expected valid=%0b grant=%b idx=%0d",
                  tag, gvalid, grant, gidx, v, eoh, ch);
      end
   endtask

   task automatic pulse_done();
      done = 1'b1;
      step();
      done = 1'b0;
   endtask

   task automatic do_reset();
      req = '0; en = '0; urg = '0; cend = '0; bexp = '0; done = 1'b0;
      rst_n = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic t_reset();
      do_reset();
      checks++;
      if (grant !== '0 || gvalid !== 1'b0 || gidx !== '0) begin
         fails++;
         $display("FAIL R1: grant=%b valid=%0b idx=%0d expected 0/0/0", grant, gvalid, gidx);
      end
   endtask

   task automatic t_tier_order();
      do_reset();
      en = '1;
      req[5] = 1'b1; req[2] = 1'b1;
      step();
      expect_grant(1, 2, "R3 normal tier lowest index");
      expect_grant(1, 2, "R2 index matches one-hot");
      do_reset();
      en = '1;
      req[1] = 1'b1; req[6] = 1'b1; urg[6] = 1'b1;
      step();
      expect_grant(1, 6, "R4 urgent beats lower normal");
      do_reset();
      en = '1;
      req[7] = 1'b1; urg[7] = 1'b1; req[3] = 1'b1; urg[3] = 1'b1; req[0] = 1'b1;
      step();
      expect_grant(1, 3, "R3 urgent tier lowest index");
   endtask

   task automatic t_disabled();
      do_reset();
      req[0] = 1'b1;
      repeat (3) step();
      expect_grant(0, 0, "R5 disabled request ignored");
      req[4] = 1'b1; en[4] = 1'b1;
      step();
      expect_grant(1, 4, "R5 enabled channel wins over disabled lower");
   endtask

   task automatic t_idle_latency();
      do_reset();
      en = '1;
      repeat (2) step();
      expect_grant(0, 0, "R9 idle without requests");
      req[6] = 1'b1;
      expect_grant(0, 0, "R9 no grant before the edge");
      step();
      expect_grant(1, 6, "R9 grant one edge after request");
   endtask

   task automatic t_burst_hold();
      do_reset();
      en = '1;
      set_exp(1, 2);
      req[1] = 1'b1;
      step();
      expect_grant(1, 1, "R7 burst owner");
      req[0] = 1'b1; urg[0] = 1'b1;
      for (int k = 0; k < 3; k++) begin
         pulse_done();
         expect_grant(1, 1, "R6 no preemption mid-burst");
      end
      pulse_done();
      expect_grant(1, 0, "R7 handover after 4 transfers");
   endtask

   task automatic t_single();
      do_reset();
      en = '1;
      set_exp(3, 0); req[3] = 1'b1; req[5] = 1'b1;
      step();
      expect_grant(1, 3, "R7 exponent 0 owner");
      req[3] = 1'b0;
      pulse_done();
      expect_grant(1, 5, "R10 back-to-back after 1 transfer");
      req[5] = 1'b0;
      set_exp(5, 0);
      cend[5] = 1'b1;
      step();
      cend[5] = 1'b0;
      expect_grant(0, 0, "R10 return to idle when nobody eligible");
   endtask

   task automatic t_clamp();
      do_reset();
      en = '1;
      set_exp(2, 15); urg[2] = 1'b1; req[2] = 1'b1; req[6] = 1'b1;
      step();
      expect_grant(1, 2, "R7 clamp owner");
      for (int k = 0; k < 1023; k++) pulse_done();
      expect_grant(1, 2, "R7 still held after 1023 transfers");
      req[2] = 1'b0;
      pulse_done();
      expect_grant(1, 6, "R7 released after 1024 transfers");
   endtask

   task automatic t_early_end();
      do_reset();
      en = '1;
      set_exp(4, 3); req[4] = 1'b1; req[7] = 1'b1;
      step();
      expect_grant(1, 4, "R8 owner before cycle end");
      pulse_done();
      pulse_done();
      cend[4] = 1'b1; req[4] = 1'b0;
      step();
      cend[4] = 1'b0;
      expect_grant(1, 7, "R8 early release on cycle end");
      do_reset();
      en = '1;
      set_exp(7, 5); req[7] = 1'b1;
      step();
      expect_grant(1, 7, "R8 owner before enable loss");
      req[0] = 1'b1;
      step();
      expect_grant(1, 7, "R6 lower index waits");
      en[7] = 1'b0;
      step();
      expect_grant(1, 0, "R8 release on enable loss");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_tier_order();
      t_disabled();
      t_idle_latency();
      t_burst_hold();
      t_single();
      t_clamp();
      t_early_end();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule